// File: doc/BRIEF.md
# Sign-split segmented DAC formatter

This block receives a stereo I2S stream and turns each audio sample into two 16-bit serial words, one per converter half. Each audio channel is served by a dual-channel current DAC whose two halves are wired as a positive segment and a negative segment. The sign of the sample, which is its first bit on the wire, selects the segment that is driven. The 16 bits that follow the sign go to that segment: unchanged on the positive path, bit-inverted on the negative path. The other segment holds its idle code. Only one segment moves for small signals, so no converter half flips all of its bits as the signal passes through zero.

Left and right samples arrive one after the other. The block holds the left sample until the right sample of the same frame is complete. It then shifts all four words out together, MSB first, on four serial lines that share one output bit clock. A single latch strobe after the 16th bit loads both channels at the same instant, so the converters run in simultaneous mode.

An optional compensation input removes the double zero code at the sign change. When it is set, the last bit of the idle segment's word copies the sample's sign bit.

Top module: `sm_seg_formatter`

The output sequencer has four states. HOLD is the state after reset: the lines stay idle and no strobe is issued. When the first left-then-right pair arrives, the move HOLD->SHIFT takes place on the next falling bit clock. SHIFT lasts 16 falling edges, one per bit, and then moves SHIFT->LATCH. LATCH lasts one bit period and then moves LATCH->WAIT. WAIT behaves like HOLD, and the next complete pair starts WAIT->SHIFT.

## Requirements
- R1: When the sample's first (sign) bit is 1, the channel's positive line carries sample bits 2 to 17, counted from the sign bit, uninverted and MSB first.
- R2: When the sign bit is 0, the channel's negative line carries the bit-inverted sample bits 2 to 17, MSB first.
- R3: With compensation off, the segment that is not selected carries all zeros (0x0000).
- R4: With compensation on, the idle segment's word is 0x0000 except for its last (16th) bit, which equals the sample's sign bit. The selected segment's word is unchanged.
- R5: Sample bits after the 17th have no effect on any output word.
- R6: Each word is exactly 16 bits long. After the 16th bit, the latch strobe is high for exactly one output bit period, and all four data lines are 0 during it.
- R7: The left sample of a frame and the right sample that follows it are issued in the same word group and loaded by the same strobe.
- R8: Input framing is I2S. The word select is low for the left channel and high for the right. The MSB arrives one bit clock after each word-select edge, and data is sampled on the rising bit clock.
- R9: From reset until the first complete left-then-right pair, all data lines are 0 and no strobe is issued. A right slot with no preceding left slot is ignored.
- R10: A slot with fewer than 17 bits is discarded and produces no strobe. A later complete left-then-right pair is issued normally.
- R11: Data lines and strobe change only right after a falling edge of the output bit clock, all in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock, faster than the bit clock |
| rst_n | input | 1 | active-low synchronous reset |
| comp_en | input | 1 | zero-crossing compensation enable |
| i2s_bck | input | 1 | I2S bit clock |
| i2s_ws | input | 1 | I2S word select, low = left |
| i2s_sd | input | 1 | I2S serial data |
| dac_bck | output | 1 | bit clock to the converters |
| dac_lpos | output | 1 | left positive segment data |
| dac_lneg | output | 1 | left negative segment data |
| dac_rpos | output | 1 | right positive segment data |
| dac_rneg | output | 1 | right negative segment data |
| dac_le | output | 1 | simultaneous latch strobe |

## Verification
The assertions assume that each bit-clock phase lasts at least two system clocks. They also assume that word select and data change only near the falling bit clock, and that a frame leaves at least 17 falling edges between the completion of one right sample and the next. The stimulus keeps within these limits. It holds each bit-clock phase for four system clocks, drives word select and data at the start of the low phase, and uses 24-bit slots, which leave 31 spare bit periods per frame. The strobe and edge checks rely on the sequencer leaving HOLD only after the receiver has seen a left slot before a right slot, so orphan and short slots are driven on purpose to exercise that path.

// File: rtl/sm_fmt_pkg.sv
package sm_fmt_pkg;
    typedef enum logic [1:0] {
        S_HOLD  = 2'd0,
        S_WAIT  = 2'd1,
        S_SHIFT = 2'd2,
        S_LATCH = 2'd3
    } ser_state_t;

    localparam int NCH = 2;
    localparam int SEGS_PER_CH = 2;
endpackage

// File: rtl/sm_i2s_rx.sv
module sm_i2s_rx #(
    parameter int SAMPLE_W = 17,
    parameter int SYNC_N   = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                i2s_bck,
    input  logic                i2s_ws,
    input  logic                i2s_sd,
    output logic                bck_q,
    output logic                fall_evt,
    output logic                pair_vld,
    output logic [SAMPLE_W-1:0] pair_l,
    output logic [SAMPLE_W-1:0] pair_r
);
    localparam int CNT_W = $clog2(SAMPLE_W + 1);
    localparam logic [CNT_W-1:0] CNT_DONE = CNT_W'(SAMPLE_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SAMPLE_W - 1);

    logic [SYNC_N-1:0]   bck_sy, ws_sy, sd_sy;
    logic                bck_s, ws_s, sd_s, rise_evt;
    logic                ws_q, chan, have_l;
    logic [CNT_W-1:0]    cnt;
    logic [SAMPLE_W-2:0] shreg;
    logic [SAMPLE_W-1:0] left_w, new_w;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bck_sy <= '0;
            ws_sy  <= '0;
            sd_sy  <= '0;
            bck_q  <= 1'b0;
        end else begin
            bck_sy <= {bck_sy[SYNC_N-2:0], i2s_bck};
            ws_sy  <= {ws_sy[SYNC_N-2:0], i2s_ws};
            sd_sy  <= {sd_sy[SYNC_N-2:0], i2s_sd};
            bck_q  <= bck_sy[SYNC_N-1];
        end
    end

    assign bck_s    = bck_sy[SYNC_N-1];
    assign ws_s     = ws_sy[SYNC_N-1];
    assign sd_s     = sd_sy[SYNC_N-1];
    assign rise_evt = bck_s & ~bck_q;
    assign fall_evt = ~bck_s & bck_q;
    assign new_w    = {shreg, sd_s};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ws_q     <= 1'b0;
            chan     <= 1'b0;
            cnt      <= CNT_DONE;
            shreg    <= '0;
            left_w   <= '0;
            have_l   <= 1'b0;
            pair_vld <= 1'b0;
            pair_l   <= '0;
            pair_r   <= '0;
        end else begin
            pair_vld <= 1'b0;
            if (rise_evt) begin
                ws_q <= ws_s;
                if (ws_s != ws_q) begin
                    cnt  <= '0;
                    chan <= ws_s;
                end else if (cnt < CNT_DONE) begin
                    shreg <= new_w[SAMPLE_W-2:0];
                    cnt   <= cnt + 1'b1;
                    if (cnt == CNT_LAST) begin
                        if (!chan) begin
                            left_w <= new_w;
                            have_l <= 1'b1;
                        end else begin
                            if (have_l) begin
                                pair_l   <= left_w;
                                pair_r   <= new_w;
                                pair_vld <= 1'b1;
                            end
                            have_l <= 1'b0;
                        end
                    end
                end
            end
        end
    end

    // R9: a pair is only issued when a left word was waiting
    p_pair_after_left_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pair_vld |-> $past(have_l));

    // R8: bit counter never runs past the sample width
    p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_DONE);

    // R8: capture only advances on a rising bit clock
    p_cnt_on_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cnt) |-> $past(rise_evt));
endmodule

// File: rtl/sm_seg_map.sv
module sm_seg_map
    import sm_fmt_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic                        comp_en,
    input  logic [NCH-1:0][WORD_W:0]    samp,
    output logic [NCH-1:0][WORD_W-1:0]  pos_w,
    output logic [NCH-1:0][WORD_W-1:0]  neg_w
);
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic              sign;
        logic [WORD_W-1:0] mag, idle_w;

        assign sign   = samp[c][WORD_W];
        assign mag    = samp[c][WORD_W-1:0];
        assign idle_w = {{(WORD_W-1){1'b0}}, comp_en & sign};

        always_comb begin
            if (sign) begin
                pos_w[c] = mag;
                neg_w[c] = idle_w;
            end else begin
                pos_w[c] = idle_w;
                neg_w[c] = ~mag;
            end
        end
    end
endmodule

// File: rtl/sm_seg_ser.sv
module sm_seg_ser
    import sm_fmt_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int NLINE  = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         fall_evt,
    input  logic                         load,
    input  logic [NLINE-1:0][WORD_W-1:0] words,
    output logic [NLINE-1:0]             sdo,
    output logic                         le
);
    localparam int BC_W = $clog2(WORD_W);
    localparam logic [BC_W-1:0] BC_LAST = BC_W'(WORD_W - 1);

    ser_state_t                   state, state_nx;
    logic [BC_W-1:0]              bitcnt;
    logic                         pend;
    logic [NLINE-1:0][WORD_W-1:0] pend_w;
    logic                         start;

    assign start = fall_evt && pend && (state == S_HOLD || state == S_WAIT);

    always_comb begin
        state_nx = state;
        unique case (state)
            S_HOLD, S_WAIT: if (start) state_nx = S_SHIFT;
            S_SHIFT:        if (fall_evt && bitcnt == BC_LAST) state_nx = S_LATCH;
            S_LATCH:        if (fall_evt) state_nx = S_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_HOLD;
            bitcnt <= '0;
            pend   <= 1'b0;
            pend_w <= '0;
        end else begin
            state <= state_nx;
            if (start) bitcnt <= '0;
            else if (fall_evt && state == S_SHIFT) bitcnt <= bitcnt + 1'b1;
            if (load) begin
                pend   <= 1'b1;
                pend_w <= words;
            end else if (start) begin
                pend <= 1'b0;
            end
        end
    end

    for (genvar i = 0; i < NLINE; i++) begin : g_line
        logic [WORD_W-1:0] sh;
        always_ff @(posedge clk) begin
            if (!rst_n) sh <= '0;
            else if (start) sh <= pend_w[i];
            else if (fall_evt && state == S_SHIFT) sh <= {sh[WORD_W-2:0], 1'b0};
        end
        assign sdo[i] = (state == S_SHIFT) & sh[WORD_W-1];
    end

    always_comb begin
        le = (state == S_LATCH);
    end

    // R9: no data leaves before the first pair
    p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_HOLD) |-> (sdo == '0 && !le));

    // R6: the strobe follows a completed shift
    p_latch_after_shift_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(le) |-> ($past(state) == S_SHIFT && $past(bitcnt) == BC_LAST));

    // R6: lines idle during the strobe
    p_latch_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        le |-> sdo == '0);

    // R11: outputs move only after a falling bit clock
    p_edge_align_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({sdo, le}) |-> $past(fall_evt));

    // R3: per channel at most one segment holds more than its last bit
    for (genvar c = 0; c < NLINE / 2; c++) begin : g_excl
        p_seg_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
            pend |-> (pend_w[2*c] == '0 || pend_w[2*c+1][WORD_W-1:1] == '0));
    end
endmodule

// File: rtl/sm_seg_formatter.sv
module sm_seg_formatter
    import sm_fmt_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int SYNC_N = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic comp_en,
    input  logic i2s_bck,
    input  logic i2s_ws,
    input  logic i2s_sd,
    output logic dac_bck,
    output logic dac_lpos,
    output logic dac_lneg,
    output logic dac_rpos,
    output logic dac_rneg,
    output logic dac_le
);
    localparam int SAMPLE_W = WORD_W + 1;
    localparam int NLINE    = NCH * SEGS_PER_CH;

    logic                         fall_evt, pair_vld;
    logic [SAMPLE_W-1:0]          pair_l, pair_r;
    logic [NCH-1:0][WORD_W:0]     samp;
    logic [NCH-1:0][WORD_W-1:0]   pos_w, neg_w;
    logic [NLINE-1:0][WORD_W-1:0] words;
    logic [NLINE-1:0]             sdo;

    sm_i2s_rx #(.SAMPLE_W(SAMPLE_W), .SYNC_N(SYNC_N)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .i2s_bck  (i2s_bck),
        .i2s_ws   (i2s_ws),
        .i2s_sd   (i2s_sd),
        .bck_q    (dac_bck),
        .fall_evt (fall_evt),
        .pair_vld (pair_vld),
        .pair_l   (pair_l),
        .pair_r   (pair_r)
    );

    assign samp[0] = pair_l;
    assign samp[1] = pair_r;

    sm_seg_map #(.WORD_W(WORD_W)) u_map (
        .comp_en (comp_en),
        .samp    (samp),
        .pos_w   (pos_w),
        .neg_w   (neg_w)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_words
        assign words[SEGS_PER_CH*c]     = pos_w[c];
        assign words[SEGS_PER_CH*c + 1] = neg_w[c];
    end

    sm_seg_ser #(.WORD_W(WORD_W), .NLINE(NLINE)) u_ser (
        .clk      (clk),
        .rst_n    (rst_n),
        .fall_evt (fall_evt),
        .load     (pair_vld),
        .words    (words),
        .sdo      (sdo),
        .le       (dac_le)
    );

    assign dac_lpos = sdo[0];
    assign dac_lneg = sdo[1];
    assign dac_rpos = sdo[2];
    assign dac_rneg = sdo[3];
endmodule

// File: tb/sm_seg_formatter_tb_top.sv
module sm_seg_formatter_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic comp_en = 1'b0;
    logic i2s_bck = 1'b0;
    logic i2s_ws = 1'b0;
    logic i2s_sd = 1'b0;
    logic dac_bck, dac_lpos, dac_lneg, dac_rpos, dac_rneg, dac_le;

    always #5 clk = ~clk;

    sm_seg_formatter dut_i (
        .clk(clk), .rst_n(rst_n), .comp_en(comp_en),
        .i2s_bck(i2s_bck), .i2s_ws(i2s_ws), .i2s_sd(i2s_sd),
        .dac_bck(dac_bck), .dac_lpos(dac_lpos), .dac_lneg(dac_lneg),
        .dac_rpos(dac_rpos), .dac_rneg(dac_rneg), .dac_le(dac_le)
    );

    // {comp, left 24-bit slot, right 24-bit slot}
    localparam logic [48:0] VEC [0:7] = '{
        {1'b0, 24'h800000, 24'h7FFFFF},
        {1'b0, 24'hC3A57F, 24'h1234AB},
        {1'b1, 24'h800000, 24'h7FFFFF},
        {1'b1, 24'hFFFFFF, 24'h000000},
        {1'b0, 24'h5A5A00, 24'hA5A5FF},
        {1'b1, 24'h2B3C7F, 24'hD4E101},
        {1'b0, 24'h000000, 24'hFFFFFF},
        {1'b1, 24'h7FFF80, 24'h80007F}
    };

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [3:0]  lines;
    logic [15:0] cap [0:3];
    logic [15:0] lat [0:3];
    int          lat_cnt = 0;
    bit          pre_noise = 1'b0;
    bit          le_err = 1'b0;
    bit          prev_le = 1'b0;
    logic        prev_bck = 1'b0;

    assign lines = {dac_rneg, dac_rpos, dac_lneg, dac_lpos};

    initial begin
        for (int c = 0; c < 4; c++) begin cap[c] = '0; lat[c] = '0; end
    end

    // monitor: converter view, sampling at rising output bit clock
    always @(negedge clk) begin
        if (rst_n && dac_bck && !prev_bck) begin
            if (dac_le) begin
                if (prev_le || lines != 4'd0) le_err = 1'b1;
                for (int c = 0; c < 4; c++) lat[c] = cap[c];
                lat_cnt++;
                prev_le = 1'b1;
            end else begin
                prev_le = 1'b0;
                if (lat_cnt == 0 && lines != 4'd0) pre_noise = 1'b1;
                for (int c = 0; c < 4; c++) cap[c] = {cap[c][14:0], lines[c]};
            end
        end
        prev_bck = dac_bck;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bit_period(input logic ws, input logic sd);
        i2s_ws  = ws;
        i2s_sd  = sd;
        i2s_bck = 1'b0;
        repeat (4) @(negedge clk);
        i2s_bck = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    // R8: ws leads the slot's MSB by one bit; last period announces the next channel
    task automatic send_slot(input logic ch, input logic [23:0] val, input int len);
        for (int k = 0; k < len; k++)
            bit_period((k == len - 1) ? ~ch : ch, val[23 - k]);
    endtask

    // expected words from R1..R5: sign = bit 23, magnitude = bits 22..7
    task automatic chk_pair(input logic [23:0] l, input logic [23:0] r, input logic comp);
        logic [23:0] s;
        logic [15:0] ep, en;
        for (int c = 0; c < 2; c++) begin
            s = (c == 0) ? l : r;
            if (s[23]) begin
                ep = s[22:7];
                en = {15'd0, comp};
                chk("R1 pos word", {16'd0, lat[2*c]}, {16'd0, ep});
                chk(comp ? "R4 idle neg" : "R3 idle neg", {16'd0, lat[2*c+1]}, {16'd0, en});
            end else begin
                ep = 16'd0;
                en = ~s[22:7];
                chk("R2 neg word", {16'd0, lat[2*c+1]}, {16'd0, en});
                chk("R3 idle pos", {16'd0, lat[2*c]}, {16'd0, ep});
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R9: reset state
        chk("R9 reset lines", {28'd0, lines}, 32'd0);
        chk("R9 reset strobe", {31'd0, dac_le}, 32'd0);

        // R9: orphan right slot with no left before it
        bit_period(1'b1, 1'b0);
        send_slot(1'b1, 24'hFFFFFF, 24);

        for (int i = 0; i < 8; i++) begin
            comp_en = VEC[i][48];
            send_slot(1'b0, VEC[i][47:24], 24);
            send_slot(1'b1, VEC[i][23:0], 24);
            if (i == 0) begin
                chk("R9 no strobe before first pair", lat_cnt, 0);
                chk("R9 idle before first pair", {31'd0, pre_noise}, 32'd0);
            end else begin
                // R7: both channels of the previous frame share one strobe
                chk("R7 strobe count", lat_cnt, i);
                // R5: low slot bits vary across vectors
                chk_pair(VEC[i-1][47:24], VEC[i-1][23:0], VEC[i-1][48]);
            end
        end
        comp_en = 1'b0;
        send_slot(1'b0, 24'h0, 24);
        send_slot(1'b1, 24'h0, 24);
        chk("R7 strobe count", lat_cnt, 8);
        chk_pair(VEC[7][47:24], VEC[7][23:0], VEC[7][48]);
        chk("R6 single quiet strobe", {31'd0, le_err}, 32'd0);

        // R10: short right slot is dropped, later full pair goes through
        begin
            int n;
            send_slot(1'b0, 24'h9ABCDE, 24);
            send_slot(1'b1, 24'h000000, 10);
            n = lat_cnt;
            chk("R10 flush pair latched", n, 9);
            send_slot(1'b0, 24'h6E0F33, 24);
            chk("R10 short slot no strobe", lat_cnt, n);
            send_slot(1'b1, 24'hB00C80, 24);
            send_slot(1'b0, 24'h000000, 24);
            chk("R10 next pair strobe", lat_cnt, n + 1);
            chk_pair(24'h6E0F33, 24'hB00C80, 1'b0);
        end
        chk("R6 single quiet strobe end", {31'd0, le_err}, 32'd0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule